// File: doc/BRIEF.md
# Alarm Interrupt and Square-Wave Pin Driver

This block drives a single shared output pin from a 32.768 kHz clock domain. A mode bit picks what the pin carries. In one mode it carries a square wave at one of four rates, taken from a free-running divider. In the other mode it carries an active-low, open-drain style interrupt, formed from two sticky alarm flags and their enable bits.

The block keeps a small control register and a status register. The control register holds the mode bit, the rate select and the two alarm enables. The status register holds the two alarm flags and an oscillator-stop flag. The alarm comparators upstream raise the flags with single-cycle match pulses. An oscillator monitor raises the stop flag with a level that rises when the oscillator halts. Software reads both registers through a plain address/data port. It clears flags by writing 0 to them and cannot set any flag by a write.

Top module: `sqw_alarm_out`

## Requirements
- R1: With the mode bit at 0, the pin carries the selected square wave, whatever the alarm flags and enables hold.
- R2: The rate field is control bits 4:3. Counting N rising clock edges since reset release, the pin equals bit 14 of N mod 32768 for code 00, bit 2 for code 01 and bit 1 for code 10. For code 11 it equals the clock level itself.
- R3: With the mode bit at 1, the pin is 0 exactly when (alarm-1 flag AND alarm-1 enable) OR (alarm-2 flag AND alarm-2 enable) holds, and 1 otherwise. The rate field has no effect on the pin in this mode.
- R4: After reset, the control register reads 0x00 and the status register reads 0x80: the stop flag is set, both alarm flags are clear, the mode is square wave and both alarm interrupts are off.
- R5: An alarm flag is set by a one-cycle pulse on its match input. It stays set until a write to the status register carries 0 in its bit. A write carrying 1 in its bit leaves it unchanged.
- R6: When a status write that would clear an alarm flag lands in the same cycle as that flag's match pulse, the flag ends up set.
- R7: The stop flag is set in the cycle after a rising edge of the oscillator-stopped input. It is cleared by writing 0 to status bit 7. It is never set by a write, and a level held high does not set it again.
- R8: Control bits 7:5 and status bits 6:2 always read 0, and writes to them are ignored.
- R9: The read port returns the live register contents combinationally, and reading changes no flag.
- R10: Address 0 selects control and address 1 selects status. In status, bit 7 is the stop flag, bit 1 is alarm 2 and bit 0 is alarm 1. In control, bit 2 is the mode, bit 1 is the alarm-2 enable and bit 0 is the alarm-1 enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Live read data of the selected register |
| alarm1Match | input | 1 | One-cycle pulse when the alarm-1 time matches |
| alarm2Match | input | 1 | One-cycle pulse when the alarm-2 time matches |
| oscStopped | input | 1 | Level, high while the oscillator is seen as stopped |
| sqwIntN | output | 1 | Shared pin: square wave, or active-low interrupt |

## Verification
The assertions treat the match inputs as pulses sampled on rising clock edges. They treat the oscillator-stopped input as a level whose rising edge is the event of interest. They also expect the write strobe to change only between edges. The stimulus meets these conditions by driving every input on the falling edge only, and by raising each match input for exactly one cycle at a time. The stop level is held for several cycles before it is released. The stimulus includes a clear and a match in the same cycle, so the set-wins case from R6 is exercised.

// File: rtl/sqwi_pkg.sv
package sqwi_pkg;
  localparam int DATA_W   = 8;
  localparam int CTRL_W   = 5;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int BIT_OSF  = 7;
  localparam int BIT_A2F  = 1;
  localparam int BIT_A1F  = 0;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_4K   = 2'b01,
    RATE_8K   = 2'b10,
    RATE_FULL = 2'b11
  } rate_e;

  typedef struct packed {
    rate_e rate;     // bits 4:3
    logic  intMode;  // bit 2
    logic  a2En;     // bit 1
    logic  a1En;     // bit 0
  } ctrl_t;

  typedef struct packed {
    logic  wrCtrl;
    logic  clrA1;
    logic  clrA2;
    logic  clrOsf;
    logic  oscRise;
    ctrl_t ctrlData;
  } strobe_t;
endpackage

// File: rtl/sqwi_ctl.sv
module sqwi_ctl
  import sqwi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              oscStopped,
  output strobe_t           stb
);
  logic prevStop;
  logic wrStat;
  logic unusedWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevStop <= 1'b0;
    else       prevStop <= oscStopped;
  end

  assign wrStat = wrEn && (addr == ADDR_STAT);
  assign unusedWr = ^wrData[6:5];

  always_comb begin
    stb          = '0;
    stb.wrCtrl   = wrEn && (addr == ADDR_CTRL);
    stb.ctrlData = ctrl_t'(wrData[CTRL_W-1:0]);
    stb.clrA1    = wrStat && !wrData[BIT_A1F];
    stb.clrA2    = wrStat && !wrData[BIT_A2F];
    stb.clrOsf   = wrStat && !wrData[BIT_OSF];
    stb.oscRise  = oscStopped && !prevStop;
  end

  // R7: a held stop level yields one rise only
  p_rise_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.oscRise |=> !stb.oscRise);

  // R10: control and status strobes are exclusive
  p_excl_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |-> !(stb.clrA1 || stb.clrA2 || stb.clrOsf));
endmodule

// File: rtl/sqwi_dp.sv
module sqwi_dp
  import sqwi_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int TAP_SLOW = 14,
  parameter int TAP_4K   = 2,
  parameter int TAP_8K   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              addr,
  input  logic              alarm1Match,
  input  logic              alarm2Match,
  output logic [DATA_W-1:0] rdData,
  output logic              sqwIntN
);
  localparam int MAX_TAP = TAP_SLOW;

  logic [CNT_W-1:0] divCnt;
  ctrl_t            ctrlReg;
  logic             a1Flag, a2Flag, osFlag;
  logic             waveOut, irqActive;
  logic             unusedCnt;

  // free-running divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end
  assign unusedCnt = ^divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctrlReg <= '0;
    else if (stb.wrCtrl) ctrlReg <= stb.ctrlData;
  end

  // sticky flags: a new event beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      a1Flag <= 1'b0;
      a2Flag <= 1'b0;
      osFlag <= 1'b1;
    end else begin
      a1Flag <= alarm1Match | (a1Flag & ~stb.clrA1);
      a2Flag <= alarm2Match | (a2Flag & ~stb.clrA2);
      osFlag <= stb.oscRise | (osFlag & ~stb.clrOsf);
    end
  end

  generate
    if (MAX_TAP < CNT_W) begin : g_rate_mux
      always_comb begin
        unique case (ctrlReg.rate)
          RATE_SLOW: waveOut = divCnt[TAP_SLOW];
          RATE_4K:   waveOut = divCnt[TAP_4K];
          RATE_8K:   waveOut = divCnt[TAP_8K];
          default:   waveOut = clk;
        endcase
      end
    end else begin : g_rate_clip
      always_comb begin
        unique case (ctrlReg.rate)
          RATE_SLOW: waveOut = divCnt[CNT_W-1];
          RATE_4K:   waveOut = divCnt[TAP_4K];
          RATE_8K:   waveOut = divCnt[TAP_8K];
          default:   waveOut = clk;
        endcase
      end
    end
  endgenerate

  assign irqActive = (a1Flag && ctrlReg.a1En) || (a2Flag && ctrlReg.a2En);
  assign sqwIntN   = ctrlReg.intMode ? ~irqActive : waveOut;

  always_comb begin
    rdData = '0;
    if (addr == ADDR_STAT) begin
      rdData[BIT_OSF] = osFlag;
      rdData[BIT_A2F] = a2Flag;
      rdData[BIT_A1F] = a1Flag;
    end else begin
      rdData[CTRL_W-1:0] = ctrlReg;
    end
  end

  // R5: a set alarm flag holds unless a clear strobe arrives
  p_a1_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (a1Flag && !stb.clrA1) |=> a1Flag);
  p_a2_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (a2Flag && !stb.clrA2) |=> a2Flag);
  // R6: a match always leaves its flag set
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    alarm1Match |=> a1Flag);
  // R7: stop flag only rises through the oscillator edge
  p_osf_no_wr_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!osFlag && !stb.oscRise) |=> !osFlag);
  p_osf_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.oscRise |=> osFlag);
  // R8: control holds without a write
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCtrl |=> $stable(ctrlReg));
  // R3: interrupt mode with no flags leaves the pin released
  p_int_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg.intMode && !a1Flag && !a2Flag) |-> sqwIntN);
endmodule

// File: rtl/sqw_alarm_out.sv
module sqw_alarm_out
  import sqwi_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        alarm1Match,
  input  logic        alarm2Match,
  input  logic        oscStopped,
  output logic        sqwIntN
);
  strobe_t stb;

  sqwi_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .oscStopped (oscStopped),
    .stb        (stb)
  );

  sqwi_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .addr        (addr),
    .alarm1Match (alarm1Match),
    .alarm2Match (alarm2Match),
    .rdData      (rdData),
    .sqwIntN     (sqwIntN)
  );
endmodule

// File: tb/sqw_alarm_out_bench.sv
module sqw_alarm_out_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       alarm1Match = 1'b0;
  logic       alarm2Match = 1'b0;
  logic       oscStopped = 1'b0;
  logic       sqwIntN;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int       mCnt = 0;
  bit       mA1 = 0, mA2 = 0, mOsf = 1, mPrev = 0;
  bit [4:0] mCtrl = '0;

  always #5 clk = ~clk;

  sqw_alarm_out u_sqw_alarm_out (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .alarm1Match(alarm1Match), .alarm2Match(alarm2Match),
    .oscStopped(oscStopped), .sqwIntN(sqwIntN)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mA1 = 0; mA2 = 0; mOsf = 1; mPrev = 0; mCtrl = '0;
    end else begin
      bit rise, wst;
      rise = oscStopped && !mPrev;
      mPrev = oscStopped;
      wst = wrEn && addr;
      mA1 = alarm1Match || (mA1 && !(wst && !wrData[0]));
      mA2 = alarm2Match || (mA2 && !(wst && !wrData[1]));
      mOsf = rise || (mOsf && !(wst && !wrData[7]));
      if (wrEn && !addr) mCtrl = wrData[4:0];
      mCnt = (mCnt + 1) % 32768;
    end
  end

  function automatic bit expPin(bit lvl);
    if (mCtrl[2]) return !((mA1 && mCtrl[0]) || (mA2 && mCtrl[1]));
    case (mCtrl[4:3])
      2'b00: return mCnt[14];
      2'b01: return mCnt[2];
      2'b10: return mCnt[1];
      default: return lvl;
    endcase
  endfunction

  function automatic bit [7:0] expRd();
    return addr ? {mOsf, 5'b0, mA2, mA1} : {3'b0, mCtrl};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll(bit lvl);
    bit e;
    e = expPin(lvl);
    chk(sqwIntN === e, "R1/R2/R3 pin", int'(sqwIntN), int'(e));
    chk(rdData === expRd(), "R9/R10 read", int'(rdData), int'(expRd()));
  endtask

  always @(posedge clk) begin
    #2;
    if (rstN && !done) compareAll(1'b1);
  end
  always @(negedge clk) begin
    #2;
    if (rstN && !done) compareAll(1'b0);
  end

  task automatic regWr(bit a, logic [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic regRd(bit a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdData;
  endtask

  task automatic pulse(bit which);
    @(negedge clk);
    if (which) alarm2Match = 1; else alarm1Match = 1;
    @(negedge clk); alarm1Match = 0; alarm2Match = 0;
  endtask

  task automatic countHigh(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #3; if (sqwIntN) h++;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    finishRun();
  end

  initial begin
    logic [7:0] d, d2;
    int h;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R4 reset state
    regRd(0, d); chk(d == 8'h00, "R4 ctrl reset", d, 8'h00);
    regRd(1, d); chk(d == 8'h80, "R4 status reset", d, 8'h80);
    // R2 rates in square-wave mode
    regWr(0, 8'h08); countHigh(64, h); chk(h == 32, "R2 rate01", h, 32);
    regWr(0, 8'h10); countHigh(64, h); chk(h == 32, "R2 rate10", h, 32);
    regWr(0, 8'h18); countHigh(64, h); chk(h == 64, "R2 rate11", h, 64);
    regWr(0, 8'h00); countHigh(32768, h); chk(h == 16384, "R2 rate00", h, 16384);
    // R3 interrupt mode with enables off
    regWr(0, 8'h04); pulse(0);
    regRd(1, d); chk(d == 8'h81, "R5 a1 set", d, 8'h81);
    chk(sqwIntN === 1'b1, "R3 disabled", int'(sqwIntN), 1);
    regWr(0, 8'h05); @(posedge clk); #3;
    chk(sqwIntN === 1'b0, "R3 a1 asserted", int'(sqwIntN), 0);
    regWr(0, 8'h1D); countHigh(16, h); chk(h == 0, "R3 rate ignored", h, 0);
    // R1 square-wave mode ignores pending alarm
    regWr(0, 8'h19); countHigh(16, h); chk(h == 16, "R1 wave over alarm", h, 16);
    regWr(0, 8'h05);
    // R5 write 1 keeps, write 0 clears
    regWr(1, 8'hFF); regRd(1, d); chk(d == 8'h81, "R5 write one", d, 8'h81);
    regWr(1, 8'hFE); regRd(1, d); chk(d == 8'h80, "R5 clear a1", d, 8'h80);
    chk(sqwIntN === 1'b1, "R3 released", int'(sqwIntN), 1);
    // R6 clear and match together
    pulse(1); regWr(0, 8'h06);
    @(negedge clk); wrEn = 1; addr = 1; wrData = 8'h80; alarm2Match = 1;
    @(negedge clk); wrEn = 0; alarm2Match = 0;
    regRd(1, d); chk(d == 8'h82, "R6 set wins", d, 8'h82);
    // R9 reads have no side effect
    regRd(1, d); regRd(1, d2); chk(d == d2, "R9 reread", d2, d);
    // R7 stop flag
    regWr(1, 8'h03); regRd(1, d); chk(d == 8'h02, "R7 clear osf", d, 8'h02);
    regWr(1, 8'h83); regRd(1, d); chk(d == 8'h02, "R7 no write set", d, 8'h02);
    @(negedge clk); oscStopped = 1;
    repeat (2) @(negedge clk);
    regRd(1, d); chk(d == 8'h82, "R7 rise sets", d, 8'h82);
    regWr(1, 8'h7F); repeat (4) @(negedge clk);
    regRd(1, d); chk(d == 8'h02, "R7 held level", d, 8'h02);
    oscStopped = 0;
    // R8 unused bits
    regWr(0, 8'hE0); regRd(0, d); chk(d == 8'h00, "R8 ctrl unused", d, 8'h00);
    regWr(1, 8'h7E); regRd(1, d); chk(d == 8'h02, "R8 stat unused", d, 8'h02);
    // R10 field positions
    regWr(0, 8'h1F); regRd(0, d); chk(d == 8'h1F, "R10 ctrl fields", d, 8'h1F);
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule